// File: doc/BRIEF.md
# Quad-Phase Oversampling Data Recovery

This block recovers a serial bit stream from an input that has no forwarded clock, and it needs no phase-locked loop. Four local clocks share one frequency, close to the bit rate, and are offset by a quarter period each. The input is sampled on the rising edge of each of them. The four samples are carried into the base clock domain (phase 0). The block then looks for level changes between neighbouring samples. From where the last change falls, it picks the sample that lies nearest the middle of a bit.

The local clock and the sender's clock never match exactly, so the chosen sample drifts across the four phases. The block handles this drift by how many bits it emits. If the selected phase steps forward across the cycle boundary, the same bit would be taken twice, so no bit is emitted that cycle. If it steps backward across the boundary, one bit would be lost, so two bits are emitted. Every cycle the block therefore delivers zero, one or two bits, together with a count. Downstream logic packs these bits into words.

Top module: `qpo_data_recovery`

## Requirements
- R1: While `rst_n` is low, `rec_count` is 0 and `rec_bits` is 0.
- R2: After reset, `rec_count` stays 0 until the first level change has reached the synchronized samples. Once that happens, the block stays locked until the next reset.
- R3: When the data rate equals the base clock rate, exactly one bit is emitted in every cycle after lock.
- R4: The recovered bits equal the transmitted bits, with no loss, repeat or reordering. `rec_bits[0]` carries the earlier bit. The sampling point follows the latest edge seen in the cycle, using this table:
  - a change between the previous cycle's phase 270 sample and phase 0 selects phase 180;
  - a change between 0 and 90 selects 270;
  - a change between 90 and 180 selects 0;
  - a change between 180 and 270 selects 90.
- R5: When the data is slower than the clock, some cycles after lock emit no bit (count 0), and none emits two. A count of 0 follows exactly the step of the selection from phase 270 to phase 0.
- R6: When the data is faster than the clock, some cycles emit two bits, and none after lock emits zero. A count of 2 follows exactly the step of the selection from phase 0 to phase 270. In that case `rec_bits[0]` is the phase 0 sample and `rec_bits[1]` is the phase 270 sample.
- R7: Over a 340-cycle window, the number of bits emitted is 340 × (clock period / bit period), within ±2.
- R8: `rec_count` is never 3. Bits at or above the count read as 0.
- R9: In a cycle with no level change, the selected phase is kept and one bit is still emitted after lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph0 | input | 1 | Base clock, phase 0; all outputs are registered on it |
| clk_ph90 | input | 1 | Same-frequency clock delayed a quarter period |
| clk_ph180 | input | 1 | Same-frequency clock delayed half a period |
| clk_ph270 | input | 1 | Same-frequency clock delayed three quarters of a period |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk_ph0 |
| serial_in | input | 1 | Asynchronous serial data |
| rec_bits | output | 2 | Recovered bits, index 0 earliest |
| rec_count | output | 2 | Number of valid bits in rec_bits (0, 1 or 2) |

## Verification
The selection update and the emission of a second bit coincide in one cycle: the cycle in which the chosen phase wraps from phase 0 back to phase 270. The mirror case is the cycle in which a forward wrap suppresses the bit. Both cases are provoked by driving a PRBS7 stream at 2% above and 2% below the clock rate. Each rate is run from eight starting offsets, so that the wrap lands against every phase pair. The result is judged by the PRBS7 recurrence, which must hold across the wrap cycles. It is also judged by the bit total over a fixed window and by the set of count values that appear at each rate.

// File: rtl/qpo_pkg.sv
`timescale 1ns/10ps
package qpo_pkg;
  localparam int unsigned NPH   = 4;
  localparam int unsigned OUT_W = 2;
  localparam int unsigned CNT_W = 2;

  typedef logic [NPH-1:0] ph_vec_t;

  // Sample index order: position in time inside one base cycle.
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2,
    PH_D = 2'd3
  } phase_e;
endpackage

// File: rtl/qpo_phase_sampler.sv
`timescale 1ns/10ps
module qpo_phase_sampler
  import qpo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_ph0,
  input  logic    clk_ph90,
  input  logic    clk_ph180,
  input  logic    clk_ph270,
  input  logic    rst_n,
  input  logic    serial_in,
  output ph_vec_t samp_sync
);
  localparam int unsigned LAST_HOP = NPH - 1;

  logic [NPH-1:0] ph_clk;
  ph_vec_t        landed;
  ph_vec_t        pipe_q [SYNC_STAGES];

  assign ph_clk = {clk_ph270, clk_ph180, clk_ph90, clk_ph0};

  // Each phase sample hops through the later phases, then lands on phase 0.
  for (genvar k = 0; k < NPH; k++) begin : g_ph
    for (genvar j = 0; j < NPH; j++) begin : g_hop
      if (j == k) begin : g_st
        logic q;
        always_ff @(posedge ph_clk[j] or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= serial_in;
        end
      end else if (j > k) begin : g_st
        logic q;
        always_ff @(posedge ph_clk[j] or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= g_hop[j-1].g_st.q;
        end
      end
    end
    logic land_q;
    always_ff @(posedge clk_ph0 or negedge rst_n) begin
      if (!rst_n) land_q <= 1'b0;
      else        land_q <= g_hop[LAST_HOP].g_st.q;
    end
    assign landed[k] = land_q;
  end

  always_ff @(posedge clk_ph0 or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= landed;
      for (int s = 1; s < SYNC_STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign samp_sync = pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/qpo_edge_finder.sv
`timescale 1ns/10ps
module qpo_edge_finder
  import qpo_pkg::*;
(
  input  logic    clk_ph0,
  input  logic    rst_n,
  input  ph_vec_t samp,
  output logic    edge_any,
  output phase_e  centre
);
  logic    prev_d_q;
  ph_vec_t edges;   // edges[i]: change just before sample i

  always_ff @(posedge clk_ph0 or negedge rst_n) begin
    if (!rst_n) prev_d_q <= 1'b0;
    else        prev_d_q <= samp[NPH-1];
  end

  assign edges[0] = prev_d_q ^ samp[0];
  for (genvar i = 1; i < NPH; i++) begin : g_cmp
    assign edges[i] = samp[i-1] ^ samp[i];
  end

  // Latest edge in the cycle wins; target is two quarters past the edge.
  always_comb begin
    edge_any = |edges;
    centre   = PH_C;
    if      (edges[3]) centre = PH_B;
    else if (edges[2]) centre = PH_A;
    else if (edges[1]) centre = PH_D;
    else if (edges[0]) centre = PH_C;
  end
endmodule

// File: rtl/qpo_bit_picker.sv
`timescale 1ns/10ps
module qpo_bit_picker
  import qpo_pkg::*;
(
  input  logic             clk_ph0,
  input  logic             rst_n,
  input  ph_vec_t          samp,
  input  logic             edge_any,
  input  phase_e           centre,
  output logic [OUT_W-1:0] rx_bits,
  output logic [CNT_W-1:0] rx_cnt
);
  phase_e           sel_q, sel_n;
  logic             locked_q, lock_n;
  logic             sel_en, lock_en;
  logic             wrap_fwd, wrap_bwd;
  logic [OUT_W-1:0] bits_q, bits_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    sel_en   = edge_any;
    lock_en  = edge_any & ~locked_q;
    sel_n    = sel_en ? centre : sel_q;
    lock_n   = locked_q | edge_any;
    wrap_fwd = (sel_q == PH_D) && (sel_n == PH_A);
    wrap_bwd = (sel_q == PH_A) && (sel_n == PH_D);
    bits_n   = '0;
    cnt_n    = '0;
    if (lock_n) begin
      if (wrap_bwd) begin
        bits_n = {samp[PH_D], samp[PH_A]};
        cnt_n  = 2'd2;
      end else if (!wrap_fwd) begin
        bits_n = {1'b0, samp[sel_n]};
        cnt_n  = 2'd1;
      end
    end
  end

  always_ff @(posedge clk_ph0 or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= PH_C;
      locked_q <= 1'b0;
      bits_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (sel_en)  sel_q    <= sel_n;
      if (lock_en) locked_q <= 1'b1;
      bits_q <= bits_n;
      cnt_q  <= cnt_n;
    end
  end

  assign rx_bits = bits_q;
  assign rx_cnt  = cnt_q;

  assert_quiet_before_lock_R2: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    (!locked_q && !edge_any) |=> (cnt_q == 2'd0));
  assert_lock_sticky_R2: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    locked_q |=> locked_q);
  assert_skip_on_forward_wrap_R5: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    (sel_q == PH_A && $past(sel_q) == PH_D) |-> (cnt_q == 2'd0));
  assert_pair_on_backward_wrap_R6: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    (sel_q == PH_D && $past(sel_q) == PH_A) |-> (cnt_q == 2'd2));
  assert_count_range_R8: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    cnt_q != 2'd3);
  assert_idle_bits_zero_R8: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    (cnt_q == 2'd0) |-> (bits_q == '0));
  assert_hold_without_edge_R9: assert property (@(posedge clk_ph0) disable iff (!rst_n)
    !edge_any |=> $stable(sel_q));
endmodule

// File: rtl/qpo_data_recovery.sv
`timescale 1ns/10ps
module qpo_data_recovery
  import qpo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_ph0,
  input  logic       clk_ph90,
  input  logic       clk_ph180,
  input  logic       clk_ph270,
  input  logic       rst_n,
  input  logic       serial_in,
  output logic [1:0] rec_bits,
  output logic [1:0] rec_count
);
  ph_vec_t samp_sync;
  logic    edge_any;
  phase_e  centre;

  qpo_phase_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk_ph0   (clk_ph0),
    .clk_ph90  (clk_ph90),
    .clk_ph180 (clk_ph180),
    .clk_ph270 (clk_ph270),
    .rst_n     (rst_n),
    .serial_in (serial_in),
    .samp_sync (samp_sync)
  );

  qpo_edge_finder i_edges (
    .clk_ph0  (clk_ph0),
    .rst_n    (rst_n),
    .samp     (samp_sync),
    .edge_any (edge_any),
    .centre   (centre)
  );

  qpo_bit_picker i_picker (
    .clk_ph0  (clk_ph0),
    .rst_n    (rst_n),
    .samp     (samp_sync),
    .edge_any (edge_any),
    .centre   (centre),
    .rx_bits  (rec_bits),
    .rx_cnt   (rec_count)
  );
endmodule

// File: tb/test_qpo_data_recovery.sv
`timescale 1ns/10ps
module test_qpo_data_recovery;
  logic       clk_ph0 = 1'b0, clk_ph90 = 1'b0, clk_ph180 = 1'b0, clk_ph270 = 1'b0;
  logic       rst_n = 1'b0;
  logic       serial_in = 1'b0;
  logic [1:0] rec_bits;
  logic [1:0] rec_count;

  int n_checks = 0;
  int n_errors = 0;
  int mon_zero, mon_one, mon_two, mon_bits, mon_perr, mon_r8;
  logic last_level;

  qpo_data_recovery i_qpo_data_recovery (
    .clk_ph0   (clk_ph0),
    .clk_ph90  (clk_ph90),
    .clk_ph180 (clk_ph180),
    .clk_ph270 (clk_ph270),
    .rst_n     (rst_n),
    .serial_in (serial_in),
    .rec_bits  (rec_bits),
    .rec_count (rec_count)
  );

  // 50 MHz, four phases 5 ns apart
  initial begin
    int s;
    s = 0;
    forever begin
      clk_ph0   = (s == 0) || (s == 1);
      clk_ph90  = (s == 1) || (s == 2);
      clk_ph180 = (s == 2) || (s == 3);
      clk_ph270 = (s == 3) || (s == 0);
      #5;
      s = (s + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_prbs(input real tbit, input real off, input int nbits);
    logic [6:0] st;
    st = 7'h7F;
    #(off);
    for (int i = 0; i < nbits; i++) begin
      serial_in  = st[6];
      last_level = st[6];
      st = {st[5:0], st[6] ^ st[5]};
      #(tbit);
    end
  endtask

  task automatic monitor(input int cycles, input int skip);
    logic [6:0] hist;
    int have;
    logic x;
    hist = '0; have = 0;
    mon_zero = 0; mon_one = 0; mon_two = 0; mon_bits = 0; mon_perr = 0; mon_r8 = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_ph0);
      if (c < skip) continue;
      if (rec_count == 2'd3) mon_r8++;
      if (rec_count < 2'd2 && rec_bits[1]) mon_r8++;
      if (rec_count == 2'd0 && rec_bits[0]) mon_r8++;
      case (rec_count)
        2'd0: mon_zero++;
        2'd1: mon_one++;
        2'd2: mon_two++;
        default: ;
      endcase
      for (int b = 0; b < 2; b++) begin
        if (b < int'(rec_count)) begin
          x = rec_bits[b];
          mon_bits++;
          if (have >= 7 && x != (hist[6] ^ hist[5])) mon_perr++;
          hist = {hist[5:0], x};
          if (have < 7) have++;
        end
      end
    end
  endtask

  initial begin
    #(3_000_000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 3; r++) begin
      for (int o = 0; o < 8; o++) begin
        real tbit;
        real off;
        int  bad;
        int  exp_bits;
        tbit = (r == 0) ? 20.0 : ((r == 1) ? 20.4 : 19.6);
        off  = 1.25 + 2.5 * o;

        rst_n = 1'b0; serial_in = 1'b0;
        repeat (3) @(negedge clk_ph0);
        check(rec_count == 2'd0 && rec_bits == 2'd0, "R1", "outputs in reset",
              {rec_count, rec_bits}, 0);
        rst_n = 1'b1;

        bad = 0;
        repeat (12) begin
          @(negedge clk_ph0);
          if (rec_count != 2'd0) bad++;
        end
        check(bad == 0, "R2", "valid before first edge", bad, 0);

        fork
          drive_prbs(tbit, off, 400);
          monitor(360, 20);
        join

        check(mon_perr == 0, "R4", "PRBS7 recurrence errors", mon_perr, 0);
        check(mon_r8 == 0, "R8", "count range / idle bits", mon_r8, 0);
        exp_bits = $rtoi(340.0 * 20.0 / tbit + 0.5);
        check(mon_bits >= exp_bits - 2 && mon_bits <= exp_bits + 2, "R7",
              "bits in window", mon_bits, exp_bits);
        if (r == 0) begin
          check(mon_zero == 0, "R3", "empty cycles at matched rate", mon_zero, 0);
          check(mon_two == 0, "R3", "double cycles at matched rate", mon_two, 0);
        end else if (r == 1) begin
          check(mon_zero > 0, "R5", "empty cycles with slow data", mon_zero, 7);
          check(mon_two == 0, "R5", "double cycles with slow data", mon_two, 0);
        end else begin
          check(mon_two > 0, "R6", "double cycles with fast data", mon_two, 7);
          check(mon_zero == 0, "R6", "empty cycles with fast data", mon_zero, 0);
        end

        repeat (8) @(negedge clk_ph0);
        bad = 0;
        repeat (6) begin
          @(negedge clk_ph0);
          if (rec_count != 2'd1 || rec_bits[0] != last_level) bad++;
        end
        check(bad == 0, "R9", "one held bit per idle cycle", bad, 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule